// File: doc/BRIEF.md
# E1 Frame Alignment Loss Monitor

This block sits behind an E1 receive framer that has already found the frame start. On every accepted bit it is told the bit's position inside the 256-bit frame. It is also told whether the current frame is one that should carry the alignment word. From that it inspects timeslot 0. It declares loss of frame alignment once enough checked words in a row arrive corrupted. It then asks the external search logic to hunt for the frame start again.

The loss rule has two settings. In one, only the alignment words count. In the other, the single fixed bit in timeslot 0 of the alternate frames counts as well. Automatic searching can be switched off, so that a loss is only flagged. Software can force a search with a rising edge on a request input. Each corrupted checked word also gives a one-clock strobe, which an outside error counter can use. The whole block is idle when the line runs in the other (non-E1) mode.

Top module: `e1_align_monitor`

## Requirements
- R1: In a frame with `fas_frame`=1, the bits at positions 1..7 (the 2nd to 8th bits of timeslot 0, position 0 being the first bit of the frame) must read 0,0,1,1,0,1,1 in that order. Any mismatch makes `err_evt` pulse for one clock, one clock after the position-7 bit is accepted. A matching word gives no pulse.
- R2: In a frame with `fas_frame`=0 and `cfg_crit`=1, a 0 at position 1 is an error and gives an `err_evt` pulse. With `cfg_crit`=0 that bit is not checked: it gives no pulse and has no effect on the error count.
- R3: A run of three erroneous checked words sets `loa` one clock after the third `err_evt` pulse.
- R4: A correctly received checked word restarts the consecutive-error run, so two errors, a good word and two more errors do not set `loa`.
- R5: With `cfg_no_auto`=0, `search_req` pulses for one clock in the same cycle that `loa` rises. With `cfg_no_auto`=1, a declared loss sets `loa` but issues no request.
- R6: A 0-to-1 transition on `sw_resync` makes `search_req` pulse once, one clock later, whether or not `loa` is set. Holding `sw_resync` at 1 issues no further request until it has returned to 0 and risen again.
- R7: `loa` stays set until `align_found` is 1 on a clock edge. While `loa` is set, no word is checked and `err_evt` stays 0.
- R8: With `e1_mode`=0, `err_evt` and `search_req` stay 0, `loa` is cleared, and the configuration and `sw_resync` have no effect.
- R9: While `rst_n` is low, `loa`, `search_req` and `err_evt` are 0 and the error run and the stored `sw_resync` value are cleared.
- R10: Each issued search request restarts the consecutive-error run: two errors, a software request and one more error do not set `loa`.
- R11: Only cycles with `bit_en`=1 are sampled. Bit values present while `bit_en`=0 never produce an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e1_mode | input | 1 | 1 = line runs in E1 mode; 0 = block idle |
| bit_en | input | 1 | Received-bit enable, one per line bit |
| rx_bit | input | 1 | Received data bit |
| bit_pos | input | 8 | Position of `rx_bit` within the frame, 0..255 |
| fas_frame | input | 1 | 1 = current frame carries the alignment word |
| cfg_crit | input | 1 | 1 = also count errors in the fixed bit of the other frames |
| cfg_no_auto | input | 1 | 1 = no automatic search on loss |
| sw_resync | input | 1 | Software search request, acts on its rising edge |
| align_found | input | 1 | Pulse from the search logic: alignment regained |
| loa | output | 1 | Loss of frame alignment flag |
| search_req | output | 1 | One-clock request to start a frame search |
| err_evt | output | 1 | One-clock strobe per erroneous checked word |

## Verification
The bench builds the block with its default parameters: a 256-bit frame and a loss threshold of three. One frame is then 256 enabled bits, and a complete loss scenario fits in six frames. That keeps the long frame and the real threshold while still allowing around a dozen loss, masking, mode and edge-detect scenarios. Gaps in `bit_en` around timeslot 0 carry inverted data, so any sampling of disabled cycles shows up as spurious errors.

// File: rtl/e1_mon_pkg.sv
package e1_mon_pkg;
  // Alignment word, positions 1..7 map to bits 6..0 (bit 7 unused).
  localparam logic [7:0] FAS_BYTE = 8'b0001_1011;
endpackage

// File: rtl/e1_ts0_checker.sv
module e1_ts0_checker #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             fas_frame,
  input  logic             crit_nfas,
  output logic             chk_valid,
  output logic             chk_bad
);
  import e1_mon_pkg::*;

  logic       mism_q, mism_n;
  logic       valid_n, bad_n;
  logic       take, in_field, at_first, at_last, exp_bit, bit_mism;
  logic [2:0] idx;

  always_comb begin
    take     = enable & bit_en;
    at_first = (bit_pos == POS_W'(1));
    at_last  = (bit_pos == POS_W'(7));
    in_field = (bit_pos >= POS_W'(1)) && (bit_pos <= POS_W'(7));
    idx      = 3'd7 - bit_pos[2:0];
    exp_bit  = FAS_BYTE[idx];
    bit_mism = (rx_bit != exp_bit);

    mism_n  = mism_q;
    valid_n = 1'b0;
    bad_n   = 1'b0;
    if (take && fas_frame && in_field) begin
      mism_n = at_first ? bit_mism : (mism_q | bit_mism);
    end
    if (take && fas_frame && at_last) begin
      valid_n = 1'b1;
      bad_n   = mism_q | bit_mism;
    end else if (take && !fas_frame && crit_nfas && at_first) begin
      valid_n = 1'b1;
      bad_n   = ~rx_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mism_q    <= 1'b0;
      chk_valid <= 1'b0;
      chk_bad   <= 1'b0;
    end else begin
      mism_q    <= mism_n;
      chk_valid <= valid_n;
      chk_bad   <= bad_n;
    end
  end

  // A result is only ever produced from a cycle with an accepted bit.
  assert_sample_on_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> ($past(bit_en) && $past(enable)));

  // Checks only land at the end of the word or on the fixed bit.
  assert_check_position_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> ($past(bit_pos) == POS_W'(7) || $past(bit_pos) == POS_W'(1)));
endmodule

// File: rtl/e1_loss_counter.sv
module e1_loss_counter #(
  parameter int LOSS_COUNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic e1_mode,
  input  logic chk_valid,
  input  logic chk_bad,
  input  logic search_req,
  input  logic align_found,
  output logic loa,
  output logic declare
);
  localparam int CNT_W = $clog2(LOSS_COUNT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOSS_COUNT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             loa_n;

  always_comb begin
    cnt_n   = cnt_q;
    loa_n   = loa;
    declare = 1'b0;
    if (!e1_mode) begin
      cnt_n = '0;
      loa_n = 1'b0;
    end else begin
      if (chk_valid && chk_bad && !loa) begin
        if (cnt_q == LAST) begin
          declare = 1'b1;
          cnt_n   = '0;
          loa_n   = 1'b1;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end else if (chk_valid && !chk_bad) begin
        cnt_n = '0;
      end
      if (search_req) begin
        cnt_n = '0;
      end
      if (align_found && loa) begin
        loa_n = 1'b0;
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      loa   <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      loa   <= loa_n;
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LOSS_COUNT));

  assert_loa_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loa) |-> ($past(chk_valid) && $past(chk_bad)));

  assert_loa_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loa && !align_found && e1_mode) |=> loa);

  assert_loa_off_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !e1_mode |=> !loa);
endmodule

// File: rtl/e1_resync_ctrl.sv
module e1_resync_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic e1_mode,
  input  logic declare,
  input  logic cfg_no_auto,
  input  logic sw_resync,
  output logic search_req
);
  logic sw_q;
  logic sw_rise, req_n;

  always_comb begin
    sw_rise = sw_resync & ~sw_q;
    req_n   = e1_mode & ((declare & ~cfg_no_auto) | sw_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q       <= 1'b0;
      search_req <= 1'b0;
    end else begin
      sw_q       <= sw_resync;
      search_req <= req_n;
    end
  end

  assert_no_req_off_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !e1_mode |=> !search_req);

  assert_held_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sw_resync) && sw_resync && !declare) |=> !search_req);
endmodule

// File: rtl/e1_align_monitor.sv
module e1_align_monitor #(
  parameter int FRAME_BITS = 256,
  parameter int LOSS_COUNT = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          e1_mode,
  input  logic                          bit_en,
  input  logic                          rx_bit,
  input  logic [$clog2(FRAME_BITS)-1:0] bit_pos,
  input  logic                          fas_frame,
  input  logic                          cfg_crit,
  input  logic                          cfg_no_auto,
  input  logic                          sw_resync,
  input  logic                          align_found,
  output logic                          loa,
  output logic                          search_req,
  output logic                          err_evt
);
  localparam int POS_W = $clog2(FRAME_BITS);

  logic chk_valid, chk_bad, declare, chk_enable;

  assign chk_enable = e1_mode & ~loa;
  assign err_evt    = chk_valid & chk_bad & e1_mode;

  e1_ts0_checker #(.POS_W(POS_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (chk_enable),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .bit_pos   (bit_pos),
    .fas_frame (fas_frame),
    .crit_nfas (cfg_crit),
    .chk_valid (chk_valid),
    .chk_bad   (chk_bad)
  );

  e1_loss_counter #(.LOSS_COUNT(LOSS_COUNT)) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .e1_mode     (e1_mode),
    .chk_valid   (chk_valid),
    .chk_bad     (chk_bad),
    .search_req  (search_req),
    .align_found (align_found),
    .loa         (loa),
    .declare     (declare)
  );

  e1_resync_ctrl u_resync (
    .clk         (clk),
    .rst_n       (rst_n),
    .e1_mode     (e1_mode),
    .declare     (declare),
    .cfg_no_auto (cfg_no_auto),
    .sw_resync   (sw_resync),
    .search_req  (search_req)
  );

  assert_auto_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(loa) && !$past(cfg_no_auto)) |-> search_req);

  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loa) |-> !err_evt);
endmodule

// File: tb/e1_align_monitor_bench.sv
module e1_align_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n, e1_mode, bit_en, rx_bit, fas_frame;
  logic       cfg_crit, cfg_no_auto, sw_resync, align_found;
  logic [7:0] bit_pos;
  logic       loa, search_req, err_evt;

  int checks = 0, errors = 0;
  int n_err = 0, n_req = 0, cyc = 0, last_err_cyc = 0, loa_rise_cyc = 0;
  logic loa_d = 1'b0;

  always #5 clk = ~clk;

  e1_align_monitor u_e1_align_monitor (
    .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .bit_en(bit_en),
    .rx_bit(rx_bit), .bit_pos(bit_pos), .fas_frame(fas_frame),
    .cfg_crit(cfg_crit), .cfg_no_auto(cfg_no_auto), .sw_resync(sw_resync),
    .align_found(align_found), .loa(loa), .search_req(search_req),
    .err_evt(err_evt)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    loa_d <= loa;
    if (err_evt) begin n_err <= n_err + 1; last_err_cyc <= cyc; end
    if (search_req) n_req <= n_req + 1;
    if (loa && !loa_d) loa_rise_cyc <= cyc;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic good_bit(input logic fas, input int p);
    logic [6:0] w = 7'b0011011;
    if (fas && p >= 1 && p <= 7) return w[7 - p];
    if (!fas && p == 1) return 1'b1;
    return p[2];
  endfunction

  task automatic run_frame(input logic fas, input logic ok, input logic gaps);
    for (int p = 0; p < 256; p++) begin
      logic v;
      v = good_bit(fas, p);
      if (!ok && ((fas && p == 3) || (!fas && p == 1))) v = ~v;
      if (gaps && p < 10) begin
        @(negedge clk);
        bit_en = 1'b0; rx_bit = ~v; bit_pos = 8'(p); fas_frame = fas;
      end
      @(negedge clk);
      bit_en = 1'b1; rx_bit = v; bit_pos = 8'(p); fas_frame = fas;
    end
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_pair(input logic fas_ok, input logic nfas_ok);
    run_frame(1'b1, fas_ok, 1'b0);
    run_frame(1'b0, nfas_ok, 1'b0);
  endtask

  task automatic sw_pulse();
    @(negedge clk); sw_resync = 1'b1;
    @(negedge clk); sw_resync = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic found();
    @(negedge clk); align_found = 1'b1;
    @(negedge clk); align_found = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; e1_mode = 1'b1; bit_en = 1'b0; rx_bit = 1'b0;
    bit_pos = '0; fas_frame = 1'b0; cfg_crit = 1'b0; cfg_no_auto = 1'b0;
    sw_resync = 1'b0; align_found = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 loa in reset", int'(loa), 0);
    check("R9 search_req in reset", int'(search_req), 0);
    check("R9 err_evt in reset", int'(err_evt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 loa after reset", int'(loa), 0);
  endtask

  task automatic t_good_with_gaps();
    int e0 = n_err;
    for (int i = 0; i < 3; i++) begin
      run_frame(1'b1, 1'b1, 1'b1);
      run_frame(1'b0, 1'b1, 1'b1);
    end
    check("R11 R1 no errors on good frames with gaps", n_err - e0, 0);
    check("R1 loa stays clear", int'(loa), 0);
  endtask

  task automatic t_run_restart();
    int e0 = n_err;
    run_pair(1'b0, 1'b0);
    run_pair(1'b0, 1'b1);
    run_pair(1'b1, 1'b1);
    run_pair(1'b0, 1'b0);
    run_pair(1'b0, 1'b1);
    check("R2 R4 errors counted, fixed bit unchecked", n_err - e0, 4);
    check("R4 good word restarts run", int'(loa), 0);
    run_pair(1'b1, 1'b1);
  endtask

  task automatic t_loss_auto();
    int e0 = n_err, q0 = n_req;
    for (int i = 0; i < 3; i++) run_pair(1'b0, 1'b1);
    check("R1 three word errors", n_err - e0, 3);
    check("R3 loa set", int'(loa), 1);
    check("R3 loa one clock after third error", loa_rise_cyc - last_err_cyc, 1);
    check("R5 one automatic request", n_req - q0, 1);
  endtask

  task automatic t_masked();
    int e0 = n_err;
    run_pair(1'b0, 1'b0);
    run_pair(1'b0, 1'b0);
    check("R7 no checks while loa", n_err - e0, 0);
    check("R7 loa held", int'(loa), 1);
    found();
    check("R7 align_found clears loa", int'(loa), 0);
  endtask

  task automatic t_crit1();
    int e0 = n_err, q0 = n_req;
    cfg_crit = 1'b1;
    run_pair(1'b1, 1'b0);
    run_pair(1'b0, 1'b0);
    check("R2 fixed bit errors counted", n_err - e0, 3);
    check("R2 loss with mixed errors", int'(loa), 1);
    check("R5 request on mixed loss", n_req - q0, 1);
    cfg_crit = 1'b0;
    found();
  endtask

  task automatic t_no_auto();
    int q0 = n_req;
    cfg_no_auto = 1'b1;
    for (int i = 0; i < 3; i++) run_pair(1'b0, 1'b1);
    check("R5 loa without auto search", int'(loa), 1);
    check("R5 no request when disabled", n_req - q0, 0);
    sw_pulse();
    check("R6 software request during loa", n_req - q0, 1);
    check("R6 loa unchanged by request", int'(loa), 1);
    found();
    cfg_no_auto = 1'b0;
  endtask

  task automatic t_sw_hold();
    int q0 = n_req;
    @(negedge clk); sw_resync = 1'b1;
    repeat (20) @(negedge clk);
    check("R6 held high gives one request", n_req - q0, 1);
    sw_resync = 1'b0;
    repeat (3) @(negedge clk);
    sw_resync = 1'b1;
    repeat (5) @(negedge clk);
    sw_resync = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 second rise gives second request", n_req - q0, 2);
  endtask

  task automatic t_req_clear();
    int e0 = n_err;
    run_pair(1'b0, 1'b1);
    run_pair(1'b0, 1'b1);
    sw_pulse();
    run_pair(1'b0, 1'b1);
    check("R10 errors seen", n_err - e0, 3);
    check("R10 request restarts run", int'(loa), 0);
    run_pair(1'b1, 1'b1);
  endtask

  task automatic t_line_mode();
    int e0, q0;
    for (int i = 0; i < 3; i++) run_pair(1'b0, 1'b1);
    @(negedge clk); e1_mode = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 loa cleared off line mode", int'(loa), 0);
    e0 = n_err; q0 = n_req;
    cfg_crit = 1'b1;
    for (int i = 0; i < 3; i++) run_pair(1'b0, 1'b0);
    sw_pulse();
    check("R8 no errors off line mode", n_err - e0, 0);
    check("R8 no requests off line mode", n_req - q0, 0);
    check("R8 loa stays clear", int'(loa), 0);
    cfg_crit = 1'b0;
    @(negedge clk); e1_mode = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_good_with_gaps();
    t_run_restart();
    t_loss_auto();
    t_masked();
    t_crit1();
    t_no_auto();
    t_sw_hold();
    t_req_clear();
    t_line_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule